// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Carry Outputs

A 4-bit synchronous counter that steps up or down by one on a rising clock edge. A parameter fixes its range at build time: a decade range (0 to 9) or a full binary range (0 to 15). The counter can be cleared at once, cleared on the next edge, or loaded with a parallel value on the next edge. It counts only while two active-low enables are both asserted.

Two active-low carry outputs let counters be chained.

- The ripple carry is combinational. It flags the terminal count for the current direction while the T enable is asserted, so it can feed the T enable of the next stage directly.
- The clocked carry is the same condition, further qualified by both enables and by the low phase of the clock. It therefore cannot pulse during the settling time after an edge.

The count leaves the block on a data bus with a separate drive flag, which stands in for a three-state pin group. The output enable only gates that bus and never affects counting.

Top module: `updown_tally`

## Requirements
- R1: While `clr_now_n` is low, `count` is 0 immediately, without waiting for a clock edge. It stays 0 across clock edges whatever the other inputs are.
- R2: With `clr_now_n` high and `clr_sync_n` low, `count` becomes 0 on the next rising edge, regardless of load, enables and direction.
- R3: With both clears high and `load_n` low, `count` takes `load_val` on the next rising edge, whatever the enables are.
- R4: With both clears and `load_n` high, the count changes only when `en_p_n` and `en_t_n` are both low; if either is high, `count` holds.
- R5: When counting, `count_up` = 1 adds one and `count_up` = 0 subtracts one.
- R6: Wrap points follow the range: decade (`DECADE` = 1) goes 9 to 0 up and 0 to 9 down; binary (`DECADE` = 0) goes 15 to 0 up and 0 to 15 down.
- R7: In decade mode a loaded value from 10 to 15 goes to 0 on the next up count and decrements by one on a down count. `ripple_n` stays high at these values.
- R8: `ripple_n` is 0 exactly when `en_t_n` is 0 and the count is at the terminal value: the range maximum when `count_up` = 1, or 0 when `count_up` = 0. Being combinational, it follows a change of `count_up` without a clock edge.
- R9: `clocked_n` is 0 only while `clk` is low, `ripple_n` is low and both enables are low; otherwise it is 1.
- R10: `q_drive` is the inverse of `oe_n`. While `q_drive` is 1, `q_bus` equals `count`; while it is 0, `q_bus` is 0. `oe_n` never changes the counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_now_n | input | 1 | Active-low clear, acts without a clock |
| clr_sync_n | input | 1 | Active-low clear, acts on the rising edge |
| load_n | input | 1 | Active-low parallel load |
| load_val | input | W | Value taken on a load |
| en_p_n | input | 1 | Active-low count enable P |
| en_t_n | input | 1 | Active-low count enable T; also gates the ripple carry |
| count_up | input | 1 | 1 counts up, 0 counts down |
| oe_n | input | 1 | Active-low output enable for the bus |
| q_bus | output | W | Count as seen on the bus, 0 when not driven |
| q_drive | output | 1 | 1 when the bus is driven |
| count | output | W | Internal count, always visible |
| ripple_n | output | 1 | Active-low combinational terminal-count carry |
| clocked_n | output | 1 | Active-low carry valid only in the clock low phase |

## Verification
The clocked assertions take the immediate clear to be the only asynchronous input. They also assume that every other input holds steady across each rising edge, and that the enable and direction inputs are settled by the sampling point in the low phase of the clock. The stimulus keeps to this by changing inputs only 2 ns after a rising edge. That leaves the whole of the low phase and the next edge with stable values. The immediate clear is asserted at that same point, so each pulse covers at least one rising edge. Loaded values span all sixteen codes, which drives the decade instance into its out-of-range states as well as its wraps.

// File: rtl/updown_tally.sv
module updown_tally #(
  parameter bit DECADE = 1'b1,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         clr_now_n,
  input  logic         clr_sync_n,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         en_p_n,
  input  logic         en_t_n,
  input  logic         count_up,
  input  logic         oe_n,
  output logic [W-1:0] q_bus,
  output logic         q_drive,
  output logic [W-1:0] count,
  output logic         ripple_n,
  output logic         clocked_n
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  logic [W-1:0] cnt;
  logic         go;
  logic [W-1:0] nxt_up;
  logic [W-1:0] nxt_dn;

  assign go     = !en_p_n && !en_t_n;
  assign nxt_up = (cnt >= TOP) ? '0 : cnt + W'(1);
  assign nxt_dn = (cnt == '0) ? TOP : cnt - W'(1);

  always_ff @(posedge clk or negedge clr_now_n) begin
    if (!clr_now_n)       cnt <= '0;
    else if (!clr_sync_n) cnt <= '0;
    else if (!load_n)     cnt <= load_val;
    else if (go)          cnt <= count_up ? nxt_up : nxt_dn;
  end

  assign ripple_n  = !(!en_t_n && (count_up ? (cnt == TOP) : (cnt == '0)));
  assign clocked_n = !(!clk && !ripple_n && go);

  assign count   = cnt;
  assign q_drive = !oe_n;
  assign q_bus   = oe_n ? '0 : cnt;

  AST_CLEAR_NOW: assert property (@(negedge clk) !clr_now_n |-> cnt == '0); // R1
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!clr_now_n)
    !clr_sync_n |=> cnt == '0); // R2
  AST_LOAD: assert property (@(posedge clk) disable iff (!clr_now_n)
    (clr_sync_n && !load_n) |=> cnt == $past(load_val)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!clr_now_n)
    (clr_sync_n && load_n && (en_p_n || en_t_n)) |=> $stable(cnt)); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!clr_now_n)
    (clr_sync_n && load_n && go && count_up && cnt < TOP) |=> cnt == $past(cnt) + W'(1)); // R5
  AST_WRAP_DN: assert property (@(posedge clk) disable iff (!clr_now_n)
    (clr_sync_n && load_n && go && !count_up && cnt == '0) |=> cnt == TOP); // R6
  AST_OVER_UP: assert property (@(posedge clk) disable iff (!clr_now_n)
    (clr_sync_n && load_n && go && count_up && cnt >= TOP) |=> cnt == '0); // R7
  AST_CARRY_LOW: assert property (@(posedge clk) disable iff (!clr_now_n)
    (go && !ripple_n) |-> !clocked_n); // R9
  AST_CARRY_HIGH: assert property (@(negedge clk) disable iff (!clr_now_n)
    clocked_n); // R9
endmodule

// File: tb/updown_tally_bench.sv
module updown_tally_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic a_n, s_n, ld_n, p_n, t_n, up, oe;
  logic [3:0] d;
  logic [3:0] bus_d, cnt_d, bus_b, cnt_b;
  logic drv_d, rip_d, clk_d, drv_b, rip_b, clk_b;
  logic [3:0] md, mb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  updown_tally #(.DECADE(1'b1), .W(4)) u_updown_tally (
    .clk(clk), .clr_now_n(a_n), .clr_sync_n(s_n), .load_n(ld_n), .load_val(d),
    .en_p_n(p_n), .en_t_n(t_n), .count_up(up), .oe_n(oe),
    .q_bus(bus_d), .q_drive(drv_d), .count(cnt_d), .ripple_n(rip_d), .clocked_n(clk_d));

  updown_tally #(.DECADE(1'b0), .W(4)) u_updown_tally_bin (
    .clk(clk), .clr_now_n(a_n), .clr_sync_n(s_n), .load_n(ld_n), .load_val(d),
    .en_p_n(p_n), .en_t_n(t_n), .count_up(up), .oe_n(oe),
    .q_bus(bus_b), .q_drive(drv_b), .count(cnt_b), .ripple_n(rip_b), .clocked_n(clk_b));

  function automatic logic [3:0] top_of(input bit dec);
    return dec ? 4'd9 : 4'd15;
  endfunction

  function automatic logic [3:0] nxt(input logic [3:0] c, input bit dec);
    if (!s_n) return 4'd0;
    if (!ld_n) return d;
    if (p_n || t_n) return c;
    if (up) return (c >= top_of(dec)) ? 4'd0 : c + 4'd1;
    return (c == 4'd0) ? top_of(dec) : c - 4'd1;
  endfunction

  function automatic string tag_of(input logic [3:0] c, input bit dec);
    if (!s_n) return "R2";
    if (!ld_n) return "R3";
    if (p_n || t_n) return "R4";
    if (dec && c > 4'd9) return "R7";
    if ((up && c == top_of(dec)) || (!up && c == 4'd0)) return "R6";
    return "R5";
  endfunction

  function automatic logic rip_of(input logic [3:0] c, input bit dec);
    return !(!t_n && (up ? (c == top_of(dec)) : (c == 4'd0)));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    string td, tb;
    @(posedge clk);
    td = tag_of(md, 1'b1);
    tb = tag_of(mb, 1'b0);
    if (!a_n) begin
      md = 4'd0; mb = 4'd0; td = "R1"; tb = "R1";
    end else begin
      md = nxt(md, 1'b1); mb = nxt(mb, 1'b0);
    end
    #1;
    chk(cnt_d == md, td, cnt_d, md);
    chk(cnt_b == mb, tb, cnt_b, mb);
    #1;
  endtask

  task automatic probe();
    logic ed, eb;
    ed = rip_of(md, 1'b1);
    eb = rip_of(mb, 1'b0);
    chk(rip_d == ed, (md > 4'd9) ? "R7" : "R8", rip_d, ed);
    chk(rip_b == eb, "R8", rip_b, eb);
    if (clk) begin
      chk(clk_d == 1'b1, "R9", clk_d, 1);
      chk(clk_b == 1'b1, "R9", clk_b, 1);
    end else begin
      chk(clk_d == !(!p_n && !t_n && !ed), "R9", clk_d, !(!p_n && !t_n && !ed));
      chk(clk_b == !(!p_n && !t_n && !eb), "R9", clk_b, !(!p_n && !t_n && !eb));
    end
    chk(drv_d == !oe, "R10", drv_d, !oe);
    if (drv_d) chk(bus_d == md, "R10", bus_d, md);
    if (drv_b) chk(bus_b == mb, "R10", bus_b, mb);
  endtask

  task automatic drive(input logic a, input logic s, input logic l, input logic [3:0] v,
                       input logic p, input logic t, input logic u, input logic o);
    a_n = a; s_n = s; ld_n = l; d = v; p_n = p; t_n = t; up = u; oe = o;
    #1;
    if (!a_n) begin
      md = 4'd0; mb = 4'd0;
      chk(cnt_d == 4'd0, "R1", cnt_d, 0);
      chk(cnt_b == 4'd0, "R1", cnt_b, 0);
    end
    probe();
    #3;
    probe();
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    a_n = 0; s_n = 1; ld_n = 0; d = 4'd5; p_n = 0; t_n = 0; up = 1; oe = 0;
    md = 0; mb = 0;
    #1;
    chk(cnt_d == 4'd0, "R1", cnt_d, 0);
    chk(cnt_b == 4'd0, "R1", cnt_b, 0);
    cyc(); cyc();
    // R3 load then R6 decade wrap 9 -> 0, binary 9 -> 10
    drive(1, 1, 0, 4'd9, 1, 1, 1, 0); cyc();
    drive(1, 1, 1, 4'd0, 0, 0, 1, 0); cyc();
    // R6 binary 15 -> 0, R7 decade 15 -> 0 with ripple high
    drive(1, 1, 0, 4'd15, 0, 0, 1, 0); cyc();
    drive(1, 1, 1, 4'd0, 0, 0, 1, 0); cyc();
    // R7 decade 12 counts down to 11
    drive(1, 1, 0, 4'd12, 1, 0, 0, 0); cyc();
    drive(1, 1, 1, 4'd0, 0, 0, 0, 0); cyc();
    // R6 down wrap from 0
    drive(1, 1, 0, 4'd0, 0, 0, 0, 0); cyc();
    drive(1, 1, 1, 4'd0, 0, 0, 0, 0); cyc();
    // R8 direction flip at held count 9/15 changes ripple without an edge
    drive(1, 1, 1, 4'd0, 1, 0, 0, 0);
    drive(1, 1, 1, 4'd0, 1, 0, 1, 0); cyc();
    // R4 enable P alone holds
    drive(1, 1, 1, 4'd0, 1, 0, 1, 0); cyc();
    // R2 sync clear beats load
    drive(1, 0, 0, 4'd6, 0, 0, 1, 0); cyc();
    // R1 immediate clear beats load
    drive(1, 1, 0, 4'd8, 1, 1, 1, 0); cyc();
    drive(0, 1, 0, 4'd7, 0, 0, 1, 0); cyc();
    // R10 counting continues with the bus released
    drive(1, 1, 1, 4'd0, 0, 0, 1, 1); cyc();
    drive(1, 1, 1, 4'd0, 0, 0, 1, 1); cyc();
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 24) != 0, ($urandom % 10) != 0, ($urandom % 6) != 0,
            4'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
            1'($urandom), ($urandom % 4) == 0);
      cyc();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule